// File: doc/BRIEF.md
# Nibble-Stream Preamble Rewriter

This block sits in line on a 4-bit nibble stream between a receive side (nibble plus a valid flag) and a transmit side (nibble plus an enable). A frame is the run of cycles in which the valid flag is high. When nothing is armed, every frame is copied to the transmit side one clock later, preamble and start delimiter included. Both sides share one clock.

A command load of a length, a delimiter-enable flag and an arm strobe sets up a one-shot rewrite. The next frame that starts after the strobe cycle has its header replaced. Its incoming nibbles, up to and including the first 0xD nibble, are dropped. The block then sends the programmed count of 0x5 nibbles, optionally followed by the delimiter pair 0x5, 0xD, and then the frame body unchanged. The body waits in a small FIFO while the new header is sent, so a longer header loses nothing. The enable stays high from the first header nibble to the last body nibble. Frames after that one pass unchanged again.

The control path is one state machine. `ST_IDLE` waits for a frame start, which is the valid flag rising. An unarmed start goes to `ST_PASS`, which copies nibbles until the valid flag drops and then returns to `ST_IDLE`. An armed start goes to `ST_HUNT`; it skips `ST_HUNT` when the first nibble is already 0xD. `ST_HUNT` drops nibbles until it sees 0xD, or returns to `ST_IDLE` if the frame ends first. On 0xD the machine enters the first header state that applies: `ST_PRE` when the count is not zero, else `ST_SFD_LO` when the delimiter is enabled, else `ST_BODY`. `ST_PRE` sends one 0x5 per cycle and leaves after the last counted nibble for `ST_SFD_LO` or `ST_BODY`. `ST_SFD_LO` sends 0x5 and moves to `ST_SFD_HI`, which sends 0xD and moves to `ST_BODY`. `ST_BODY` drains the FIFO and returns to `ST_IDLE` once the FIFO is empty and the valid flag is low. The gap between a rewritten frame and the next frame must exceed the number of cycles the FIFO still needs to drain.

Top module: `mii_hdr_rewriter`

## Requirements
- R1: After reset the transmit enable is low and no rewrite is armed, so the first frame passes unchanged.
- R2: Every unarmed frame appears on the transmit side nibble for nibble, with the enable high for each nibble. The first nibble is sent exactly one clock after it is sampled.
- R3: An arm strobe captures the length and delimiter flag present in its cycle. A later strobe before the frame starts replaces both values. The rewrite applies to the first frame whose start (the valid flag rising) falls in a later cycle than the strobe.
- R4: With the delimiter enabled, a rewritten frame sends exactly N nibbles of 0x5, then 0x5, then 0xD, then the body. The body is every nibble after the first incoming 0xD, in order.
- R5: With the delimiter disabled, the N nibbles of 0x5 are followed directly by the body.
- R6: A length of zero sends no 0x5 padding. If the delimiter is also disabled, the output begins with the first body nibble.
- R7: A programmed length above 38 is treated as 38.
- R8: A rewrite is one-shot: the frame after a rewritten frame passes unchanged unless a new strobe was given.
- R9: A strobe during a frame, or in the cycle in which a frame starts, leaves that frame unchanged and rewrites the following frame.
- R10: For every length from 0 to 38 and any body length, the transmit enable of a rewritten frame forms one unbroken run and no body nibble is lost, duplicated or reordered.
- R11: A rewritten frame that holds no 0xD nibble produces no transmit activity, and it still uses up the armed rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dat | input | NIB_W (4) | Received nibble |
| rx_vld | input | 1 | Receive valid; high for the whole frame |
| cfg_len | input | LW (6) | Number of 0x5 header nibbles, 0 to 38 |
| cfg_sfd_en | input | 1 | Send the 0x5, 0xD delimiter pair after the padding |
| cfg_arm | input | 1 | One-cycle strobe that arms a rewrite of the next frame |
| tx_dat | output | NIB_W (4) | Transmitted nibble; zero when the enable is low |
| tx_en | output | 1 | Transmit enable |

## Verification
A stuck or skipped state shows up at the transmit port within a frame. Leaving `ST_PRE` one count early or late shifts every later nibble and changes the captured length. Missing the 0xD in `ST_HUNT` puts delimiter nibbles into the body, or drops the whole frame. A wrong armed flag shows up on the very next frame, as a rewrite that should not happen or one that is missing. A FIFO pointer slip breaks the enable into two runs, or corrupts body nibbles within the header length of the first body nibble. The sweep covers every length with both delimiter settings and three incoming preamble lengths. It compares whole captured streams, so any of these faults appears as a length, segment or nibble mismatch on the frame where it happens.

// File: rtl/mhr_pkg.sv
package mhr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_HUNT,
        ST_PRE,
        ST_SFD_LO,
        ST_SFD_HI,
        ST_BODY
    } mhr_state_t;

    localparam logic [3:0] NIB_PAD  = 4'h5;
    localparam logic [3:0] NIB_MARK = 4'hD;

endpackage

// File: rtl/mhr_arm_reg.sv
module mhr_arm_reg #(
    parameter int MAX_PRE = 38,
    parameter int LW      = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_sfd_en,
    input  logic          cfg_arm,
    input  logic          take,
    output logic          armed,
    output logic [LW-1:0] arm_len,
    output logic          arm_sfd
);
    localparam logic [LW-1:0] MAX_L = LW'(MAX_PRE);

    logic [LW-1:0] len_clamped;

    // lengths beyond the limit saturate
    assign len_clamped = (cfg_len > MAX_L) ? MAX_L : cfg_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            arm_len <= '0;
            arm_sfd <= 1'b0;
        end else if (cfg_arm) begin
            // a new strobe wins over consumption in the same cycle
            armed   <= 1'b1;
            arm_len <= len_clamped;
            arm_sfd <= cfg_sfd_en;
        end else if (take) begin
            armed   <= 1'b0;
        end
    end

endmodule

// File: rtl/mhr_fifo.sv
module mhr_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_q;
    logic [AW:0]  rd_q;
    logic         do_push;
    logic         do_pop;

    assign empty   = (wr_q == rd_q);
    assign full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q[AW-1:0]] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
        end
    end

endmodule

// File: rtl/mii_hdr_rewriter.sv
module mii_hdr_rewriter
    import mhr_pkg::*;
#(
    parameter int NIB_W      = 4,
    parameter int MAX_PRE    = 38,
    parameter int FIFO_DEPTH = 64,
    localparam int LW        = $clog2(MAX_PRE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] rx_dat,
    input  logic             rx_vld,
    input  logic [LW-1:0]    cfg_len,
    input  logic             cfg_sfd_en,
    input  logic             cfg_arm,
    output logic [NIB_W-1:0] tx_dat,
    output logic             tx_en
);
    localparam logic [NIB_W-1:0] PAD  = NIB_W'(NIB_PAD);
    localparam logic [NIB_W-1:0] MARK = NIB_W'(NIB_MARK);

    mhr_state_t       st_q;
    mhr_state_t       st_d;
    logic             rx_prev;
    logic             start;
    logic             is_mark;
    logic             take;
    logic             armed;
    logic [LW-1:0]    arm_len;
    logic             arm_sfd;
    logic [LW-1:0]    cnt_q;
    logic             cur_sfd;
    logic             emit_en;
    logic [NIB_W-1:0] emit_dat;
    logic             fifo_push;
    logic             fifo_pop;
    logic             fifo_empty;
    logic             fifo_full;
    logic [NIB_W-1:0] fifo_dout;

    // first header state that applies for a given count and delimiter choice
    function automatic mhr_state_t hdr_entry(input logic [LW-1:0] n, input logic s);
        if (n != '0) return ST_PRE;
        if (s)       return ST_SFD_LO;
        return ST_BODY;
    endfunction

    assign start   = rx_vld && !rx_prev;
    assign is_mark = rx_vld && (rx_dat == MARK);
    assign take    = (st_q == ST_IDLE) && start && armed;

    mhr_arm_reg #(
        .MAX_PRE (MAX_PRE),
        .LW      (LW)
    ) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_len    (cfg_len),
        .cfg_sfd_en (cfg_sfd_en),
        .cfg_arm    (cfg_arm),
        .take       (take),
        .armed      (armed),
        .arm_len    (arm_len),
        .arm_sfd    (arm_sfd)
    );

    mhr_fifo #(
        .W     (NIB_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (rx_dat),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // working copy of the rewrite, taken at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev <= 1'b0;
            cnt_q   <= '0;
            cur_sfd <= 1'b0;
        end else begin
            rx_prev <= rx_vld;
            if (take) begin
                cnt_q   <= arm_len;
                cur_sfd <= arm_sfd;
            end else if (st_q == ST_PRE) begin
                cnt_q   <= cnt_q - LW'(1);
            end
        end
    end

    // next state and emitted nibble
    always_comb begin
        st_d      = st_q;
        emit_en   = 1'b0;
        emit_dat  = rx_dat;
        fifo_push = 1'b0;
        fifo_pop  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (armed) begin
                        st_d = is_mark ? hdr_entry(arm_len, arm_sfd) : ST_HUNT;
                    end else begin
                        st_d    = ST_PASS;
                        emit_en = 1'b1;
                    end
                end
            end
            ST_PASS: begin
                if (rx_vld) emit_en = 1'b1;
                else        st_d    = ST_IDLE;
            end
            ST_HUNT: begin
                if (!rx_vld)      st_d = ST_IDLE;
                else if (is_mark) st_d = hdr_entry(cnt_q, cur_sfd);
            end
            ST_PRE: begin
                emit_en   = 1'b1;
                emit_dat  = PAD;
                fifo_push = rx_vld;
                if (cnt_q == LW'(1)) st_d = cur_sfd ? ST_SFD_LO : ST_BODY;
            end
            ST_SFD_LO: begin
                emit_en   = 1'b1;
                emit_dat  = PAD;
                fifo_push = rx_vld;
                st_d      = ST_SFD_HI;
            end
            ST_SFD_HI: begin
                emit_en   = 1'b1;
                emit_dat  = MARK;
                fifo_push = rx_vld;
                st_d      = ST_BODY;
            end
            ST_BODY: begin
                fifo_push = rx_vld;
                fifo_pop  = !fifo_empty;
                emit_en   = !fifo_empty;
                emit_dat  = fifo_dout;
                if (fifo_empty && !rx_vld) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en  <= 1'b0;
            tx_dat <= '0;
        end else begin
            tx_en  <= emit_en;
            tx_dat <= emit_en ? emit_dat : '0;
        end
    end

endmodule

// File: rtl/mhr_chk.sv
module mhr_chk
    import mhr_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_vld,
    input logic [NIB_W-1:0] rx_dat,
    input logic             tx_en,
    input logic [NIB_W-1:0] tx_dat,
    input mhr_state_t       st,
    input logic             push,
    input logic             full
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !rx_vld) |=> !tx_en);                                  // R1

    AST_PASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASS && rx_vld) |=> (tx_en && tx_dat == $past(rx_dat)));      // R2

    AST_PAD_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRE) |=> (tx_en && tx_dat == NIB_W'(NIB_PAD)));               // R4

    AST_SFD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SFD_LO) |=> (st == ST_SFD_HI && tx_dat == NIB_W'(NIB_PAD)));  // R4

    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HUNT) |=> !tx_en);                                             // R11

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));                                                        // R10

endmodule

bind mii_hdr_rewriter mhr_chk #(.NIB_W(NIB_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_vld (rx_vld),
    .rx_dat (rx_dat),
    .tx_en  (tx_en),
    .tx_dat (tx_dat),
    .st     (st_q),
    .push   (fifo_push),
    .full   (fifo_full)
);

// File: tb/mii_hdr_rewriter_tb.sv
module mii_hdr_rewriter_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rx_dat = '0;
    logic       rx_vld = 1'b0;
    logic [5:0] cfg_len = '0;
    logic       cfg_sfd_en = 1'b0;
    logic       cfg_arm = 1'b0;
    logic [3:0] tx_dat;
    logic       tx_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [3:0] cap [0:511];
    int cap_n = 0;
    int seg_n = 0;
    int first_tx = -1;
    logic tx_prev = 1'b0;

    logic [3:0] sent [0:255];
    int sent_n = 0;
    logic [3:0] body [0:255];
    int body_n = 0;
    logic [3:0] expv [0:511];
    int exp_n = 0;
    int st_c = 0;

    always #2.5 clk = ~clk;

    mii_hdr_rewriter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_dat     (rx_dat),
        .rx_vld     (rx_vld),
        .cfg_len    (cfg_len),
        .cfg_sfd_en (cfg_sfd_en),
        .cfg_arm    (cfg_arm),
        .tx_dat     (tx_dat),
        .tx_en      (tx_en)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tx_en) begin
            if (cap_n < 512) cap[cap_n] = tx_dat;
            if (cap_n == 0) first_tx = cyc;
            cap_n++;
            if (!tx_prev) seg_n++;
        end
        tx_prev = tx_en;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clr_cap();
        cap_n = 0;
        seg_n = 0;
        first_tx = -1;
    endtask

    task automatic arm(input int len, input bit sfd);
        @(negedge clk);
        cfg_len = 6'(len);
        cfg_sfd_en = sfd;
        cfg_arm = 1'b1;
        @(negedge clk);
        cfg_arm = 1'b0;
    endtask

    // npre pad nibbles, optional 0xD mark, nbody body nibbles; optional strobe at index arm_at
    task automatic send(input int npre, input bit with_d, input int nbody, input int seed,
                        input int arm_at, input int a_len, input bit a_sfd);
        sent_n = 0;
        body_n = 0;
        for (int i = 0; i < npre; i++) begin
            sent[sent_n] = 4'h5;
            sent_n++;
        end
        if (with_d) begin
            sent[sent_n] = 4'hD;
            sent_n++;
        end
        for (int k = 0; k < nbody; k++) begin
            body[k] = 4'((seed * 7 + k * 5 + k / 3) & 15);
            sent[sent_n] = body[k];
            sent_n++;
        end
        body_n = nbody;
        clr_cap();
        for (int i = 0; i < sent_n; i++) begin
            @(negedge clk);
            rx_vld = 1'b1;
            rx_dat = sent[i];
            if (i == 0) st_c = cyc + 1;
            if (i == arm_at) begin
                cfg_len = 6'(a_len);
                cfg_sfd_en = a_sfd;
                cfg_arm = 1'b1;
            end else begin
                cfg_arm = 1'b0;
            end
        end
        @(negedge clk);
        rx_vld = 1'b0;
        rx_dat = '0;
        cfg_arm = 1'b0;
        repeat (90) @(negedge clk);
    endtask

    task automatic exp_pass();
        exp_n = sent_n;
        for (int i = 0; i < sent_n; i++) expv[i] = sent[i];
    endtask

    task automatic exp_mod(input int len, input bit sfd);
        int l;
        l = (len > 38) ? 38 : len;
        exp_n = 0;
        for (int i = 0; i < l; i++) begin
            expv[exp_n] = 4'h5;
            exp_n++;
        end
        if (sfd) begin
            expv[exp_n] = 4'h5;
            expv[exp_n + 1] = 4'hD;
            exp_n += 2;
        end
        for (int k = 0; k < body_n; k++) begin
            expv[exp_n] = body[k];
            exp_n++;
        end
    endtask

    task automatic cmp(input string req);
        int bad_i;
        bad_i = -1;
        chk(cap_n == exp_n, req, "stream length", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            if (bad_i < 0 && cap[i] !== expv[i]) bad_i = i;
        end
        if (bad_i >= 0) chk(1'b0, req, $sformatf("nibble %0d", bad_i), int'(cap[bad_i]), int'(expv[bad_i]));
        else            chk(1'b1, req, "nibbles", 0, 0);
        if (exp_n > 0) chk(seg_n == 1, req, "enable runs", seg_n, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_en == 1'b0, "R1", "tx_en after reset", int'(tx_en), 0);

        // R1: first frame after reset passes unchanged
        send(15, 1, 20, 1, -1, 0, 0);
        exp_pass();
        cmp("R1");
        // R2: one-cycle latency and verbatim copy
        chk(first_tx == st_c, "R2", "pass latency cycle", first_tx, st_c);
        send(3, 1, 9, 2, -1, 0, 0);
        exp_pass();
        cmp("R2");
        send(0, 0, 12, 3, -1, 0, 0);
        exp_pass();
        cmp("R2");

        // R4/R5/R6/R10: every length, both delimiter settings, three preamble lengths
        for (int l = 0; l <= 38; l++) begin
            for (int s = 0; s < 2; s++) begin
                int np;
                np = (l % 3 == 0) ? 15 : ((l % 3 == 1) ? 1 : 0);
                arm(l, s[0]);
                send(np, 1, 10 + l % 7, l + s, -1, 0, 0);
                exp_mod(l, s[0]);
                if (l == 0)  cmp("R6");
                else if (s)  cmp("R4");
                else         cmp("R5");
            end
        end

        // R10: long body behind the longest header
        arm(38, 1);
        send(15, 1, 120, 9, -1, 0, 0);
        exp_mod(38, 1);
        cmp("R10");

        // R7: clamping
        arm(45, 1);
        send(15, 1, 14, 4, -1, 0, 0);
        exp_mod(38, 1);
        cmp("R7");
        arm(63, 0);
        send(2, 1, 11, 5, -1, 0, 0);
        exp_mod(38, 0);
        cmp("R7");

        // R8: one-shot
        arm(6, 1);
        send(15, 1, 16, 6, -1, 0, 0);
        exp_mod(6, 1);
        cmp("R8");
        send(15, 1, 16, 7, -1, 0, 0);
        exp_pass();
        cmp("R8");

        // R3: a later strobe replaces the earlier one
        arm(3, 1);
        arm(7, 0);
        send(15, 1, 13, 8, -1, 0, 0);
        exp_mod(7, 0);
        cmp("R3");

        // R9: strobe mid-frame
        send(15, 1, 20, 10, 10, 4, 1);
        exp_pass();
        cmp("R9");
        send(15, 1, 12, 11, -1, 0, 0);
        exp_mod(4, 1);
        cmp("R9");
        // R9: strobe in the start cycle
        send(15, 1, 10, 12, 0, 9, 0);
        exp_pass();
        cmp("R9");
        send(5, 1, 10, 13, -1, 0, 0);
        exp_mod(9, 0);
        cmp("R9");

        // R11: armed frame with no 0xD stays silent and uses up the rewrite
        arm(5, 1);
        send(20, 0, 0, 14, -1, 0, 0);
        chk(cap_n == 0, "R11", "nibbles sent for frame without mark", cap_n, 0);
        send(15, 1, 10, 15, -1, 0, 0);
        exp_pass();
        cmp("R11");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule